// File: doc/BRIEF.md
# Indirect Register Access Microport

This block is a byte-wide host port that reaches a wide internal register space by indirect addressing. The host sees a 3-bit external address, an 8-bit data bus, an active-low chip select, two active-low strobes and a mode pin. Behind the external addresses sit a channel/high-address register, a low-address register, a control register and three holding bytes that together hold one 20-bit internal word. The internal side gets a 10-bit address, a 6-bit channel-select vector and a 20-bit write word, and gives back a 20-bit read word.

One data byte starts the internal transfer. A host write to the low holding byte starts an internal write of the assembled word, so the two upper bytes must be written first. A host read of the low holding byte starts an internal read and returns the low byte. Later reads of the two upper bytes return the rest of that captured word without a new transfer. The internal request works like valid/ready. `int_wr` or `int_rd` is the valid. It stays high, with address and data stable, until the responder raises `int_done` for one cycle, and the responder may stall for any number of cycles. Every other external register completes in one cycle and makes no internal request.

The host strobes pass through a synchronizer and access detection is edge-based, so one strobe pulse makes one access. Several accesses may follow each other while chip select stays low. The mode pin is latched at the start of each access and selects the acknowledge style. In mode 0, `rdy` falls when the access is detected and rises when the access completes. In mode 1, `rdy` acts as an active-low acknowledge: it falls when the access completes and stays low until the strobe is released.

Top module: `indirect_microport`

## Requirements
- R1: After reset all holding, address and control registers read zero, `rdy` is high, `int_wr`/`int_rd` are low, and `sleep_en`, `serial_readback` and `alt_map` are zero.
- R2: External address 7 holds the channel/high-address byte and external address 6 holds the low-address byte. `int_addr` = {byte7[1:0], byte6} and `int_chan` = byte7[7:2]. The two bytes may be written in either order.
- R3: External address 2 holds only four bits. Written bits 7:4 are discarded, and a read returns bits 7:4 as zero.
- R4: A host write to external address 0 stores the byte and then raises `int_wr` exactly once. `int_wdata` = {addr2[3:0], addr1, addr0}. `int_wr`, `int_wdata` and `int_addr` stay stable until `int_done`.
- R5: A host read of external address 0 raises `int_rd` exactly once and returns `int_rdata[7:0]` after completion. Later reads of addresses 1 and 2 return `int_rdata[15:8]` and `int_rdata[19:16]` of that same word, with no new request.
- R6: Reads and writes of external addresses 1 to 7 never raise `int_wr` or `int_rd`.
- R7: The control register is at external address 5. Bits 3:0 drive `sleep_en`, bit 4 drives `serial_readback` and bit 5 drives `alt_map`. Bits 7:6 are discarded on write and read as zero.
- R8: With mode 0 latched, `rdy` is low from access detection until completion, and it stays low while an internal request is pending. For an address-0 access, `rdy` rises only after `int_done`.
- R9: With mode 1 latched, `rdy` goes low only when the access is complete, which for address 0 means after `int_done`. It stays low until the strobe or chip select is released, and then it returns high.
- R10: One strobe pulse with chip select low makes exactly one access, and back-to-back pulses under a held chip select each make one access. A strobe pulse while chip select is high has no effect.
- R11: External addresses 3 and 4 read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Host chip select, active low |
| rd_n | input | 1 | Host read strobe (data strobe in mode 1), active low |
| wr_n | input | 1 | Host write strobe, active low |
| mode | input | 1 | Handshake style: 0 ready-low-while-busy, 1 acknowledge-when-done |
| ext_addr | input | 3 | External register select |
| host_din | input | 8 | Host write data |
| host_dout | output | 8 | Host read data for the selected external register |
| rdy | output | 1 | Ready (mode 0) or active-low acknowledge (mode 1) |
| int_addr | output | 10 | Internal register address |
| int_chan | output | 6 | Internal channel-select vector |
| int_wdata | output | 20 | Internal write word |
| int_wr | output | 1 | Internal write request, held until done |
| int_rd | output | 1 | Internal read request, held until done |
| int_rdata | input | 20 | Internal read word, valid with int_done |
| int_done | input | 1 | Internal completion pulse |
| sleep_en | output | 4 | Per-channel sleep enables |
| serial_readback | output | 1 | Serial readback enable flag |
| alt_map | output | 1 | Selects the alternate input-port control map |

## Verification
Two events can fall in the same cycle. The first is the internal completion, which loads the returned word into the holding bytes and ends the request. The second is the handshake change, which releases `rdy` in mode 0 or lowers the acknowledge in mode 1. The bench sets up this coincidence on every address-0 read in both modes. It then samples `host_dout` in the first cycle the handshake allows, and the byte must already be the one just returned. It also counts responder completions and checks that the handshake never changes before the completion count has advanced.

// File: rtl/mport_pkg.sv
package mport_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_LOCAL = 2'd2,
    ST_HOLD  = 2'd3
  } acc_state_e;

  localparam logic [2:0] EA_DR0   = 3'd0;
  localparam logic [2:0] EA_DR1   = 3'd1;
  localparam logic [2:0] EA_DR2   = 3'd2;
  localparam logic [2:0] EA_CTL   = 3'd5;
  localparam logic [2:0] EA_LADDR = 3'd6;
  localparam logic [2:0] EA_CHAN  = 3'd7;
endpackage

// File: rtl/mport_strobe_sync.sv
module mport_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rd_n,
  input  logic wr_n,
  output logic rd_start,
  output logic wr_start,
  output logic strobe_active
);
  logic [STAGES-1:0] cs_q, rd_q, wr_q;
  logic rd_act, wr_act, rd_act_q, wr_act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= '1;
      rd_q <= '1;
      wr_q <= '1;
    end else begin
      cs_q <= {cs_q[STAGES-2:0], cs_n};
      rd_q <= {rd_q[STAGES-2:0], rd_n};
      wr_q <= {wr_q[STAGES-2:0], wr_n};
    end
  end

  assign rd_act = ~cs_q[STAGES-1] & ~rd_q[STAGES-1];
  assign wr_act = ~cs_q[STAGES-1] & ~wr_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_act_q <= 1'b0;
      wr_act_q <= 1'b0;
    end else begin
      rd_act_q <= rd_act;
      wr_act_q <= wr_act;
    end
  end

  assign rd_start      = rd_act & ~rd_act_q;
  assign wr_start      = wr_act & ~wr_act_q;
  assign strobe_active = rd_act | wr_act;
endmodule

// File: rtl/mport_regs.sv
module mport_regs
  import mport_pkg::*;
#(
  parameter int IA_W = 10,
  parameter int ID_W = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [2:0]              sel,
  input  logic [7:0]              wr_byte,
  input  logic                    load_rd,
  input  logic [ID_W-1:0]         rdata,
  output logic [7:0]              rd_byte,
  output logic [IA_W-1:0]         int_addr,
  output logic [8-(IA_W-8)-1:0]   chan,
  output logic [ID_W-1:0]         wdata,
  output logic [3:0]              sleep_en,
  output logic                    serial_rb,
  output logic                    alt_map
);
  localparam int HI_W   = ID_W - 16;
  localparam int AHI_W  = IA_W - 8;

  logic [7:0]      dr0_q, dr1_q, car_q, acr_q;
  logic [HI_W-1:0] dr2_q;
  logic [5:0]      ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr0_q <= '0;
      dr1_q <= '0;
      dr2_q <= '0;
      car_q <= '0;
      acr_q <= '0;
      ctl_q <= '0;
    end else if (load_rd) begin
      dr0_q <= rdata[7:0];
      dr1_q <= rdata[15:8];
      dr2_q <= rdata[ID_W-1:16];
    end else if (wr_en) begin
      case (sel)
        EA_DR0:   dr0_q <= wr_byte;
        EA_DR1:   dr1_q <= wr_byte;
        EA_DR2:   dr2_q <= wr_byte[HI_W-1:0];
        EA_CTL:   ctl_q <= wr_byte[5:0];
        EA_LADDR: car_q <= wr_byte;
        EA_CHAN:  acr_q <= wr_byte;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      EA_DR0:   rd_byte = dr0_q;
      EA_DR1:   rd_byte = dr1_q;
      EA_DR2:   rd_byte = {{(8-HI_W){1'b0}}, dr2_q};
      EA_CTL:   rd_byte = {2'b00, ctl_q};
      EA_LADDR: rd_byte = car_q;
      EA_CHAN:  rd_byte = acr_q;
      default:  rd_byte = 8'h00;
    endcase
  end

  assign int_addr  = {acr_q[AHI_W-1:0], car_q};
  assign chan      = acr_q[7:AHI_W];
  assign wdata     = {dr2_q, dr1_q, dr0_q};
  assign sleep_en  = ctl_q[3:0];
  assign serial_rb = ctl_q[4];
  assign alt_map   = ctl_q[5];
endmodule

// File: rtl/mport_fsm.sv
module mport_fsm
  import mport_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode,
  input  logic       rd_start,
  input  logic       wr_start,
  input  logic       strobe_active,
  input  logic [2:0] sel,
  input  logic       int_done,
  output logic       accept_wr,
  output logic       load_rd,
  output logic       int_wr,
  output logic       int_rd,
  output logic       rdy,
  output logic       mode_q
);
  acc_state_e state_q;
  logic       op_rd_q;
  logic       start;

  assign start     = (state_q == ST_IDLE) & (rd_start | wr_start);
  assign accept_wr = start & wr_start;
  assign load_rd   = (state_q == ST_WAIT) & op_rd_q & int_done;
  assign int_wr    = (state_q == ST_WAIT) & ~op_rd_q;
  assign int_rd    = (state_q == ST_WAIT) & op_rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_rd_q <= 1'b0;
      mode_q  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          op_rd_q <= ~wr_start;
          mode_q  <= mode;
          if (sel == EA_DR0) state_q <= ST_WAIT;
          else               state_q <= mode ? ST_HOLD : ST_LOCAL;
        end
        ST_WAIT:  if (int_done) state_q <= mode_q ? ST_HOLD : ST_IDLE;
        ST_LOCAL: state_q <= ST_IDLE;
        ST_HOLD:  if (!strobe_active) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    if (mode_q) rdy = (state_q != ST_HOLD);
    else        rdy = (state_q != ST_WAIT) && (state_q != ST_LOCAL);
  end
endmodule

// File: rtl/indirect_microport.sv
module indirect_microport #(
  parameter int IA_W        = 10,
  parameter int ID_W        = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cs_n,
  input  logic                  rd_n,
  input  logic                  wr_n,
  input  logic                  mode,
  input  logic [2:0]            ext_addr,
  input  logic [7:0]            host_din,
  output logic [7:0]            host_dout,
  output logic                  rdy,
  output logic [IA_W-1:0]       int_addr,
  output logic [16-IA_W-1:0]    int_chan,
  output logic [ID_W-1:0]       int_wdata,
  output logic                  int_wr,
  output logic                  int_rd,
  input  logic [ID_W-1:0]       int_rdata,
  input  logic                  int_done,
  output logic [3:0]            sleep_en,
  output logic                  serial_readback,
  output logic                  alt_map
);
  logic rd_start, wr_start, strobe_active;
  logic accept_wr, load_rd, mode_lat;

  mport_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .rd_start(rd_start), .wr_start(wr_start), .strobe_active(strobe_active)
  );

  mport_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .mode(mode), .rd_start(rd_start),
    .wr_start(wr_start), .strobe_active(strobe_active), .sel(ext_addr),
    .int_done(int_done), .accept_wr(accept_wr), .load_rd(load_rd),
    .int_wr(int_wr), .int_rd(int_rd), .rdy(rdy), .mode_q(mode_lat)
  );

  mport_regs #(.IA_W(IA_W), .ID_W(ID_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(accept_wr), .sel(ext_addr),
    .wr_byte(host_din), .load_rd(load_rd), .rdata(int_rdata),
    .rd_byte(host_dout), .int_addr(int_addr), .chan(int_chan),
    .wdata(int_wdata), .sleep_en(sleep_en), .serial_rb(serial_readback),
    .alt_map(alt_map)
  );
endmodule

// File: rtl/mport_checker.sv
module mport_checker #(
  parameter int IA_W = 10,
  parameter int ID_W = 20
) (
  input logic            clk,
  input logic            rst_n,
  input logic [2:0]      ext_addr,
  input logic [7:0]      host_dout,
  input logic            rdy,
  input logic            mode_lat,
  input logic [IA_W-1:0] int_addr,
  input logic [ID_W-1:0] int_wdata,
  input logic            int_wr,
  input logic            int_rd,
  input logic            int_done
);
  assert_req_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(int_wr && int_rd));

  assert_wr_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (int_wr && !int_done) |=> int_wr);

  assert_wdata_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (int_wr && !int_done) |=> $stable(int_wdata));

  assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((int_wr || int_rd) && !int_done) |=> $stable(int_addr));

  assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_lat && (int_wr || int_rd)) |-> !rdy);

  assert_no_early_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_lat && (int_wr || int_rd)) |-> rdy);

  assert_dr2_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_addr == 3'd2) |-> (host_dout[7:4] == 4'h0));

  assert_ctl_reserved_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_addr == 3'd5) |-> (host_dout[7:6] == 2'b00));

  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_addr == 3'd3 || ext_addr == 3'd4) |-> (host_dout == 8'h00));
endmodule

bind indirect_microport mport_checker #(.IA_W(IA_W), .ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr), .host_dout(host_dout),
  .rdy(rdy), .mode_lat(mode_lat), .int_addr(int_addr),
  .int_wdata(int_wdata), .int_wr(int_wr), .int_rd(int_rd),
  .int_done(int_done)
);

// File: tb/indirect_microport_tb.sv
`timescale 1ns/1ps
module indirect_microport_tb;
  localparam int LAT = 4;

  logic clk = 0, rst_n = 0;
  logic cs_n = 1, rd_n = 1, wr_n = 1, mode = 0;
  logic [2:0] ext_addr = 0;
  logic [7:0] host_din = 0, host_dout;
  logic rdy, int_wr, int_rd, serial_readback, alt_map;
  logic [9:0] int_addr;
  logic [5:0] int_chan;
  logic [19:0] int_wdata, int_rdata = 0;
  logic int_done = 0;
  logic [3:0] sleep_en;

  int n_chk = 0, n_bad = 0;
  int wr_txn = 0, rd_txn = 0, done_cnt = 0, cnt = 0;
  logic wr_prev = 0, rd_prev = 0;
  logic [19:0] mem [1024];
  bit finished = 0;

  always #10 clk = ~clk;

  indirect_microport u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .mode(mode), .ext_addr(ext_addr), .host_din(host_din),
    .host_dout(host_dout), .rdy(rdy), .int_addr(int_addr),
    .int_chan(int_chan), .int_wdata(int_wdata), .int_wr(int_wr),
    .int_rd(int_rd), .int_rdata(int_rdata), .int_done(int_done),
    .sleep_en(sleep_en), .serial_readback(serial_readback), .alt_map(alt_map)
  );

  // internal responder: completes LAT cycles after a request appears
  always @(posedge clk) begin
    if (rst_n) begin
      wr_prev <= int_wr;
      rd_prev <= int_rd;
      if (int_wr && !wr_prev) wr_txn <= wr_txn + 1;
      if (int_rd && !rd_prev) rd_txn <= rd_txn + 1;
      int_done <= 1'b0;
      if ((int_wr || int_rd) && !int_done) begin
        if (cnt == LAT - 1) begin
          cnt <= 0;
          int_done <= 1'b1;
          done_cnt <= done_cnt + 1;
          if (int_wr) mem[int_addr] <= int_wdata;
          else        int_rdata <= mem[int_addr];
        end else cnt <= cnt + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_rdy(input logic lvl, output bit ok);
    ok = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (rdy === lvl) begin ok = 1; break; end
    end
  endtask

  task automatic access(input bit is_wr, input logic [2:0] a, input logic [7:0] d,
                        output logic [7:0] q);
    bit ok;
    int d0;
    @(negedge clk);
    ext_addr = a; host_din = d; d0 = done_cnt;
    @(negedge clk);
    if (is_wr) wr_n = 0; else rd_n = 0;
    if (!mode) begin
      wait_rdy(1'b0, ok);
      chk("R8 busy seen", ok, 1);
      wait_rdy(1'b1, ok);
      chk("R8 release", ok, 1);
      if (a == 3'd0) chk("R8 done before ready", done_cnt - d0, 1);
      q = host_dout;
    end else begin
      wait_rdy(1'b0, ok);
      chk("R9 ack seen", ok, 1);
      if (a == 3'd0) chk("R9 done before ack", done_cnt - d0, 1);
      q = host_dout;
      repeat (3) @(negedge clk);
      chk("R9 ack held", rdy, 0);
    end
    wr_n = 1; rd_n = 1;
    if (mode) begin
      wait_rdy(1'b1, ok);
      chk("R9 ack released", ok, 1);
    end
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [7:0] rnd8();
    return 8'($urandom);
  endfunction

  initial begin
    logic [7:0] q;
    int w0, r0;
    void'($urandom(32'd1234));
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rdy", rdy, 1);
    chk("R1 req", {int_wr, int_rd}, 0);
    chk("R1 ctl outs", {sleep_en, serial_readback, alt_map}, 0);
    for (int a = 0; a < 8; a++) begin
      ext_addr = 3'(a); #1;
      chk("R1 reg zero", host_dout, 0);
    end
    cs_n = 0;

    // R2: both write orders
    access(1, 3'd7, 8'hA6, q); access(1, 3'd6, 8'h3C, q);
    chk("R2 addr", int_addr, 10'h23C); chk("R2 chan", int_chan, 6'h29);
    access(1, 3'd6, 8'h81, q); access(1, 3'd7, 8'h0D, q);
    chk("R2 addr rev", int_addr, 10'h181); chk("R2 chan rev", int_chan, 6'h03);

    // R3 and R6
    w0 = wr_txn; r0 = rd_txn;
    access(1, 3'd2, 8'hF9, q); access(0, 3'd2, 8'h00, q);
    chk("R3 dr2 readback", q, 8'h09);
    access(1, 3'd1, 8'h5A, q); access(0, 3'd1, 8'h00, q);
    chk("R6 dr1 readback", q, 8'h5A);
    chk("R6 no txn", {wr_txn - w0, rd_txn - r0}, 0);

    // R4 write, R5 read back, mode 0
    access(1, 3'd0, 8'hC3, q);
    chk("R4 one write", wr_txn - w0, 1);
    chk("R4 stored word", mem[10'h181], 20'h95AC3);
    mem[10'h181] = 20'h7E41B;
    access(0, 3'd0, 8'h00, q); chk("R5 low byte", q, 8'h1B);
    access(0, 3'd1, 8'h00, q); chk("R5 mid byte", q, 8'hE4);
    access(0, 3'd2, 8'h00, q); chk("R5 high nibble", q, 8'h07);
    chk("R5 one read", rd_txn - r0, 1);

    // R7 control
    access(1, 3'd5, 8'hFF, q); access(0, 3'd5, 8'h00, q);
    chk("R7 readback", q, 8'h3F);
    chk("R7 outs", {sleep_en, serial_readback, alt_map}, 6'h3F);
    access(1, 3'd5, 8'h25, q);
    chk("R7 outs2", {sleep_en, serial_readback, alt_map}, {4'h5, 1'b0, 1'b1});

    // R11 unmapped
    w0 = wr_txn;
    access(1, 3'd3, 8'hAA, q); access(0, 3'd3, 8'h00, q); chk("R11 addr3", q, 0);
    access(1, 3'd4, 8'h55, q); access(0, 3'd4, 8'h00, q); chk("R11 addr4", q, 0);
    chk("R6 unmapped no txn", wr_txn - w0, 0);

    // R10: pulse with chip select high is ignored
    cs_n = 1; ext_addr = 3'd1; host_din = 8'h11;
    @(negedge clk); wr_n = 0; repeat (6) @(negedge clk); wr_n = 1;
    repeat (4) @(negedge clk);
    cs_n = 0;
    access(0, 3'd1, 8'h00, q); chk("R10 cs high ignored", q, 8'hE4);

    // mode 1 directed then random mix (R9, R10)
    mode = 1;
    access(1, 3'd0, 8'h77, q);
    chk("R9 write stored", mem[10'h181], 20'h7E477);
    for (int it = 0; it < 40; it++) begin
      logic [9:0] ia;
      logic [19:0] wd;
      logic [7:0] hi;
      ia = 10'($urandom); wd = 20'($urandom); hi = rnd8();
      mode = 1'($urandom);
      w0 = wr_txn; r0 = rd_txn;
      if ($urandom % 2) begin
        access(1, 3'd6, ia[7:0], q); access(1, 3'd7, {hi[5:0], ia[9:8]}, q);
      end else begin
        access(1, 3'd7, {hi[5:0], ia[9:8]}, q); access(1, 3'd6, ia[7:0], q);
      end
      chk("R2 rand addr", int_addr, ia);
      chk("R2 rand chan", int_chan, hi[5:0]);
      access(1, 3'd2, {rnd8() & 8'hF0 | {4'h0, wd[19:16]}}, q);
      access(1, 3'd1, wd[15:8], q);
      access(1, 3'd0, wd[7:0], q);
      chk("R4 rand word", mem[ia], wd);
      mem[ia] = ~wd;
      access(0, 3'd0, 8'h00, q); chk("R5 rand b0", q, 8'(~wd[7:0]));
      access(0, 3'd1, 8'h00, q); chk("R5 rand b1", q, 8'(~wd[15:8]));
      access(0, 3'd2, 8'h00, q); chk("R5 rand b2", q, {4'h0, ~wd[19:16]});
      chk("R10 one txn each", {wr_txn - w0, rd_txn - r0}, {32'd1, 32'd1});
    end

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule